// File: doc/BRIEF.md
# Burst SRAM Cycle Decoder

This block sits behind the control pins of a flow-through synchronous burst SRAM. On each rising clock edge it sorts the pins into one of four actions. A cycle can be a deselect, the start of a burst at a new external address, a continuation that steps to the next address in the burst, or a suspension that stays on the current address. In the same step it decides whether the cycle reads or writes, and which 9-bit byte lanes a write touches.

The block registers the selection state, the per-lane write strobes, the write data and the burst address on the edge that starts the cycle. The array can therefore be read in that same cycle with no output register. The burst order within an aligned group of four words is either linear or interleaved, chosen by a static input. The data-output enable combines the registered read state with the asynchronous output enable and the sleep input. While asleep, every register holds its value.

Top module: `burst_cycle_ctrl`

## Requirements
- R1: A start strobe selects the device only when `sel_en_n`=0, `sel_pos`=1 and `sel_neg_n`=0. A start with any of these three unmet gives a deselected cycle: `chip_active`=0, `dq_oe`=0, `wr_lane`=0, and `mem_addr` keeps its previous value.
- R2: `cpu_strb_n` has effect only while `sel_en_n`=0. With `sel_en_n`=1 and `ctl_strb_n`=1, the cycle is a continue or suspend cycle.
- R3: A cycle started by `cpu_strb_n`=0 with `sel_en_n`=0 is a read, and all write controls are ignored. This holds even when `ctl_strb_n` is low at the same edge.
- R4: A cycle started by `ctl_strb_n`=0 alone, with the device selected, loads `addr_in` into `mem_addr` and may write in that same cycle.
- R5: `wall_n`=0 writes all lanes (`wr_lane` all ones), whatever the lane enables are. Otherwise, with `lane_gate_n`=0, lane n is written when `lane_n[n]`=0. With `lane_gate_n`=1, no lane is written.
- R6: With both start strobes high and the device selected, `step_n`=0 moves to the next word of the burst and `step_n`=1 keeps the address. The burst stays inside its aligned four-word group and returns to the first address after four words.
- R7: A cycle that writes any lane has `dq_oe`=0.
- R8: The address of a cycle appears on `mem_addr` right after the edge that starts the cycle. Data written at an address can be read back at that address in the next cycle.
- R9: `dq_oe`=1 only when the device is selected, the cycle reads, `out_en_n`=0 and `sleep`=0. `out_en_n` acts without waiting for a clock edge.
- R10: While `sleep`=1, every register holds its value, `dq_oe`=0 and `wr_lane`=0.
- R11: `wr_data` holds `wdata_in` captured on the same edge as the write strobes. Lane n occupies bits 9n to 9n+8.
- R12: After reset, `chip_active`=0, `dq_oe`=0, `wr_lane`=0, `load_addr`=0 and `mem_addr`=0.
- R13: Let b be the two low bits of the start address and k the beat count. With `order_il`=0 the low address bits are (b+k) mod 4. With `order_il`=1 they are b XOR k.
- R14: Continue and suspend cycles keep the selection state of the last start, so a continue cycle after a deselect neither writes nor moves the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| sel_en_n | input | 1 | Chip enable, active low; also gates `cpu_strb_n` |
| sel_pos | input | 1 | Chip select, active high |
| sel_neg_n | input | 1 | Chip select, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low, read-only start |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wall_n | input | 1 | Write of all lanes, active low |
| lane_gate_n | input | 1 | Enables the per-lane write selects, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep: freezes the state and disables outputs |
| addr_in | input | AW | External address |
| wdata_in | input | LANES*LW | Write data |
| chip_active | output | 1 | Registered selection state |
| load_addr | output | 1 | Current cycle loaded an external address |
| adv_step | output | 1 | Current cycle advanced the burst |
| mem_addr | output | AW | Array address for the current cycle |
| wr_lane | output | LANES | Lanes to write with `wr_data` at `mem_addr` |
| wr_data | output | LANES*LW | Registered write data |
| dq_oe | output | 1 | Data output driver enable |

## Verification
The assertions assume that `order_il` stays constant while the device runs, and that every control input is settled at each rising edge. They also assume that the device is deselected on the first edge after sleep ends. The bench drives all inputs on falling edges, sets the burst order only while no burst is running, and leaves sleep with a deselecting start strobe. The only input it moves between edges is `out_en_n`, which is asynchronous by definition.

// File: rtl/burst_cycle_ctrl.sv
`timescale 1ns/100ps
module burst_cycle_ctrl #(
  parameter int AW    = 18,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             order_il,
  input  logic             sel_en_n,
  input  logic             sel_pos,
  input  logic             sel_neg_n,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             step_n,
  input  logic             wall_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             out_en_n,
  input  logic             sleep,
  input  logic [AW-1:0]    addr_in,
  input  logic [DW-1:0]    wdata_in,
  output logic             chip_active,
  output logic             load_addr,
  output logic             adv_step,
  output logic [AW-1:0]    mem_addr,
  output logic [LANES-1:0] wr_lane,
  output logic [DW-1:0]    wr_data,
  output logic             dq_oe
);

  logic             awake, chip_ok, cpu_go, ctl_go, start, begin_ok, step;
  logic             sel_q, sel_nxt, ld_q, st_q;
  logic [LANES-1:0] req, wr_q, wr_nxt;
  logic [AW-3:0]    hi_q;
  logic [1:0]       base_lo_q, lo_q, cnt_q, cnt_nxt, lo_nxt;
  logic [DW-1:0]    din_q;

  assign awake    = !sleep;
  assign chip_ok  = !sel_en_n && sel_pos && !sel_neg_n;
  assign cpu_go   = !cpu_strb_n && !sel_en_n;
  assign ctl_go   = !ctl_strb_n;
  assign start    = cpu_go || ctl_go;
  assign begin_ok = start && chip_ok;
  assign step     = !start && sel_q && !step_n;

  assign req = !wall_n      ? {LANES{1'b1}} :
               !lane_gate_n ? ~lane_n       : '0;

  always_comb begin
    wr_nxt = '0;
    if (begin_ok && !cpu_go) wr_nxt = req;
    else if (!start && sel_q) wr_nxt = req;
  end

  assign sel_nxt = start ? chip_ok : sel_q;
  assign cnt_nxt = cnt_q + 2'd1;
  assign lo_nxt  = order_il ? (base_lo_q ^ cnt_nxt) : (base_lo_q + cnt_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      wr_q      <= '0;
      din_q     <= '0;
      ld_q      <= 1'b0;
      st_q      <= 1'b0;
      hi_q      <= '0;
      base_lo_q <= '0;
      lo_q      <= '0;
      cnt_q     <= '0;
    end else if (awake) begin
      sel_q <= sel_nxt;
      wr_q  <= wr_nxt;
      din_q <= wdata_in;
      ld_q  <= begin_ok;
      st_q  <= step;
      if (begin_ok) begin
        hi_q      <= addr_in[AW-1:2];
        base_lo_q <= addr_in[1:0];
        lo_q      <= addr_in[1:0];
        cnt_q     <= '0;
      end else if (step) begin
        cnt_q <= cnt_nxt;
        lo_q  <= lo_nxt;
      end
    end
  end

  assign chip_active = sel_q;
  assign load_addr   = ld_q;
  assign adv_step    = st_q;
  assign mem_addr    = {hi_q, lo_q};
  assign wr_lane     = wr_q & {LANES{awake}};
  assign wr_data     = din_q;
  assign dq_oe       = sel_q && (wr_q == '0) && !out_en_n && awake;

  AST_DESEL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (awake && start && !chip_ok) |=> (!chip_active && wr_lane == '0)); // R1
  AST_CPU_READS: assert property (@(posedge clk) disable iff (!rst_n) (awake && cpu_go && chip_ok) |=> (wr_lane == '0)); // R3
  AST_GLOBAL_WR: assert property (@(posedge clk) disable iff (!rst_n) (awake && !wall_n && sel_nxt && !(cpu_go && chip_ok)) |=> (&wr_q)); // R5
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (awake && !start && step_n) |=> $stable(mem_addr)); // R6
  AST_BURST_GROUP: assert property (@(posedge clk) disable iff (!rst_n) (awake && !start) |=> (mem_addr[AW-1:2] == $past(mem_addr[AW-1:2]))); // R6
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) sleep |=> ($stable(mem_addr) && $stable(chip_active))); // R10

  always_comb begin
    if (dq_oe) AST_WR_NO_OE: assert (wr_lane == '0); // R7
  end

endmodule

// File: tb/sim_burst_cycle_ctrl.sv
`timescale 1ns/100ps
module sim_burst_cycle_ctrl;
  localparam int AW = 8, LANES = 4, LW = 9, DW = LANES * LW;

  typedef struct packed {
    logic       ce_n, cs_p, cs_n, cpu_n, ctl_n, adv_n, gw_n, gate_n;
    logic [3:0] bw_n;
    logic       oe_n;
    logic [7:0] a;
    logic       e_sel, e_oe;
    logic [3:0] e_wr;
    logic [7:0] e_addr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{0,1,0,0,1,1,0,1,4'hF,0,8'h15, 1,1,4'h0,8'h15},  // R3 cpu start read, write ignored
    '{1,0,1,1,1,0,1,1,4'hF,0,8'h00, 1,1,4'h0,8'h16},  // R6 advance
    '{1,0,1,1,1,0,0,1,4'hF,0,8'h00, 1,0,4'hF,8'h17},  // R5 R7 global write in continue
    '{1,0,1,1,1,0,1,1,4'hF,0,8'h00, 1,1,4'h0,8'h14},  // R6 group wrap
    '{1,0,1,1,1,0,1,1,4'hF,0,8'h00, 1,1,4'h0,8'h15},  // R6 back to first
    '{1,0,1,1,1,1,1,1,4'hF,0,8'h00, 1,1,4'h0,8'h15},  // R6 suspend
    '{0,1,0,1,0,1,1,0,4'hA,0,8'h20, 1,0,4'h5,8'h20},  // R4 ctl start with lane writes
    '{0,1,0,1,0,1,1,1,4'h0,0,8'h30, 1,1,4'h0,8'h30},  // R5 gate blocks lanes
    '{0,0,0,1,0,1,1,1,4'hF,0,8'h44, 0,0,4'h0,8'h30},  // R1 positive select low
    '{1,0,1,1,1,0,0,1,4'hF,0,8'h00, 0,0,4'h0,8'h30},  // R14 continue while deselected
    '{0,1,0,0,1,1,1,1,4'hF,0,8'h40, 1,1,4'h0,8'h40},
    '{1,1,0,0,1,0,1,1,4'hF,0,8'h77, 1,1,4'h0,8'h41},  // R2 cpu strobe gated off
    '{1,1,0,1,0,1,1,1,4'hF,0,8'h66, 0,0,4'h0,8'h41},  // R1 enable high
    '{0,1,1,0,1,1,1,1,4'hF,0,8'h55, 0,0,4'h0,8'h41},  // R1 negative select high
    '{0,1,0,0,1,1,1,1,4'hF,1,8'h52, 1,0,4'h0,8'h52},  // R9 output enable high
    '{0,1,0,0,0,1,0,0,4'h0,0,8'h60, 1,1,4'h0,8'h60}   // R3 both strobes, cpu wins
  };

  logic clk = 0, rst_n = 0, order_il = 0;
  logic sel_en_n, sel_pos, sel_neg_n, cpu_strb_n, ctl_strb_n, step_n, wall_n, lane_gate_n, out_en_n, sleep;
  logic [LANES-1:0] lane_n;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] wdata_in;
  logic chip_active, load_addr, adv_step, dq_oe;
  logic [AW-1:0] mem_addr;
  logic [LANES-1:0] wr_lane;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] arr [256];
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_cycle_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .order_il(order_il), .sel_en_n(sel_en_n), .sel_pos(sel_pos),
    .sel_neg_n(sel_neg_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .wall_n(wall_n), .lane_gate_n(lane_gate_n), .lane_n(lane_n), .out_en_n(out_en_n),
    .sleep(sleep), .addr_in(addr_in), .wdata_in(wdata_in), .chip_active(chip_active),
    .load_addr(load_addr), .adv_step(adv_step), .mem_addr(mem_addr), .wr_lane(wr_lane),
    .wr_data(wr_data), .dq_oe(dq_oe));

  always @(posedge clk)
    for (int l = 0; l < LANES; l++)
      if (wr_lane[l]) arr[mem_addr][l*LW +: LW] <= wr_data[l*LW +: LW];

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    sel_en_n = 1; sel_pos = 0; sel_neg_n = 1; cpu_strb_n = 1; ctl_strb_n = 1;
    step_n = 1; wall_n = 1; lane_gate_n = 1; lane_n = '1; out_en_n = 0; addr_in = '0;
  endtask

  task automatic apply(input vec_t v);
    sel_en_n = v.ce_n; sel_pos = v.cs_p; sel_neg_n = v.cs_n; cpu_strb_n = v.cpu_n;
    ctl_strb_n = v.ctl_n; step_n = v.adv_n; wall_n = v.gw_n; lane_gate_n = v.gate_n;
    lane_n = v.bw_n; out_en_n = v.oe_n; addr_in = v.a;
  endtask

  task automatic cycle(input vec_t v);
    @(negedge clk); apply(v); @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(); sleep = 0; wdata_in = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    check("R12 active", chip_active, 0);
    check("R12 oe", dq_oe, 0);
    check("R12 lanes", wr_lane, 0);
    check("R12 load", load_addr, 0);
    check("R12 addr", mem_addr, 0);

    for (int i = 0; i < NV; i++) begin
      cycle(TBL[i]);
      check($sformatf("row %0d active", i), chip_active, TBL[i].e_sel);
      check($sformatf("row %0d oe", i), dq_oe, TBL[i].e_oe);
      check($sformatf("row %0d lanes", i), wr_lane, TBL[i].e_wr);
      check($sformatf("row %0d addr", i), mem_addr, TBL[i].e_addr);
    end

    // R13 interleaved order from low bits 10
    @(negedge clk); idle(); order_il = 1;
    cycle('{0,1,0,0,1,1,1,1,4'hF,0,8'h06, 0,0,0,0});
    check("R13 start", mem_addr, 8'h06);
    check("R4 load", load_addr, 1);
    cycle('{1,0,1,1,1,0,1,1,4'hF,0,8'h00, 0,0,0,0});
    check("R13 beat1", mem_addr, 8'h07);
    check("R6 step flag", adv_step, 1);
    cycle('{1,0,1,1,1,0,1,1,4'hF,0,8'h00, 0,0,0,0});
    check("R13 beat2", mem_addr, 8'h04);
    cycle('{1,0,1,1,1,0,1,1,4'hF,0,8'h00, 0,0,0,0});
    check("R13 beat3", mem_addr, 8'h05);
    @(negedge clk); idle(); order_il = 0;

    // R11 single lane write data
    @(negedge clk); wdata_in = 36'h9_A5C3_7E21;
    apply('{0,1,0,1,0,1,1,0,4'hD,0,8'h33, 0,0,0,0});
    @(posedge clk); #1;
    check("R11 lane", wr_lane, 4'b0010);
    check("R11 data", wr_data[17:9], 9'(36'h9_A5C3_7E21 >> 9));

    // R8 flow-through read-back in the next cycle
    cycle('{0,1,0,0,1,1,1,1,4'hF,0,8'h33, 0,0,0,0});
    check("R8 addr", mem_addr, 8'h33);
    check("R8 data", arr[mem_addr][17:9], 9'(36'h9_A5C3_7E21 >> 9));

    // R9 asynchronous output enable
    check("R9 oe on", dq_oe, 1);
    #0.5 out_en_n = 1; #0.5;
    check("R9 oe async off", dq_oe, 0);

    // R10 sleep freezes state and blocks writes
    cycle('{0,1,0,0,1,1,1,1,4'hF,0,8'h80, 0,0,0,0});
    @(negedge clk);
    apply('{1,0,1,1,1,0,0,1,4'hF,0,8'h00, 0,0,0,0}); sleep = 1; #0.5;
    check("R10 oe", dq_oe, 0);
    repeat (3) @(posedge clk); #1;
    check("R10 addr", mem_addr, 8'h80);
    check("R10 active", chip_active, 1);
    check("R10 lanes", wr_lane, 0);
    @(negedge clk); sleep = 0;
    apply('{1,1,0,1,0,1,1,1,4'hF,0,8'h00, 0,0,0,0});
    @(posedge clk); #1;
    check("R1 wake deselect", chip_active, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule